// File: doc/BRIEF.md
# L2 Snoop Forwarding Controller

This block is the inquire sequencer of a look-through second-level cache controller. When system logic holds the controller in back-off and strobes an external inquire (snoop), the block looks up its own tags through a simple lookup port. A miss ends the sequence quietly. A hit is reported to system logic as a hit-modified indication. Only after that report does the block take the processor's address bus with an address-hold signal. It then forwards the snoop address to the processor with a one-cycle inquire strobe.

The processor's hit-modified answer is sampled in a short window after the strobe. If the processor answers, it may hold a newer copy than the L2. The block then waits for the processor's writeback, which goes to memory and into the L2. That writeback is granted only while system logic keeps back-off removed. A build parameter selects whether address-hold is kept through the writeback or dropped as soon as the processor's hit is seen. An inquire that arrives during a running sequence is parked and started once the sequence is over.

Top module: `snoop_relay_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output strobe and indication is low: sys_hitm_o, tag_lookup_o, cpu_ahold_o, cpu_inq_o and cpu_wb_grant_o. A reset in the middle of a sequence drops address-hold at the next clock.
- R2: A system inquire sampled at a clock edge produces a tag lookup on tag_lookup_o, with the snoop address on tag_addr_o, in the cycle after the next edge. This happens while sys_backoff_i is high.
- R3: If tag_hit_i is low during the lookup cycle, the block never raises sys_hitm_o, cpu_ahold_o or cpu_inq_o for that inquire, and it is idle in the cycle after the lookup.
- R4: If tag_hit_i is high during the lookup cycle, sys_hitm_o rises one cycle later and stays high until the sequence ends. cpu_ahold_o rises one cycle after sys_hitm_o.
- R5: cpu_inq_o is a single-cycle pulse issued exactly once per hit, one cycle after cpu_ahold_o rises, with the snoop address on cpu_inq_addr_o.
- R6: cpu_hitm_i is sampled only in the two cycles that follow the strobe cycle, and is ignored at any other time. If it is not seen there, cpu_ahold_o and sys_hitm_o fall three cycles after the strobe, and no writeback is granted.
- R7: After a processor hit, cpu_wb_grant_o is high exactly while the block waits for the writeback and sys_backoff_i is low. It is never high while sys_backoff_i is high.
- R8: With the default build, cpu_ahold_o stays high through the writeback. The sequence ends, with sys_hitm_o and cpu_ahold_o low, one cycle after cpu_wb_done_i is seen together with the grant.
- R9: With the early-release build, cpu_ahold_o is low from the cycle after the processor hit onward. The writeback grant comes in the same cycle as in the default build.
- R10: An inquire that arrives while a sequence is running is kept. Its lookup appears in the cycle after the block becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_inq_i | input | 1 | System-side inquire strobe, one cycle |
| sys_inq_addr_i | input | AW | Snoop address from the system bus |
| sys_backoff_i | input | 1 | Back-off from system logic to this controller |
| sys_hitm_o | output | 1 | Hit report to system logic |
| tag_lookup_o | output | 1 | Tag lookup request |
| tag_addr_o | output | AW | Address for the tag lookup |
| tag_hit_i | input | 1 | Tag hit answer, valid in the lookup cycle |
| cpu_ahold_o | output | 1 | Address-hold to the processor |
| cpu_inq_o | output | 1 | Forwarded inquire strobe to the processor |
| cpu_inq_addr_o | output | AW | Snoop address driven to the processor |
| cpu_hitm_i | input | 1 | Processor hit-modified answer |
| cpu_wb_grant_o | output | 1 | Processor writeback may proceed |
| cpu_wb_done_i | input | 1 | Processor writeback complete |

## Verification
A wrong sequencer state shows at the ports within one or two clocks. Every phase has a distinct signature on sys_hitm_o, cpu_ahold_o and cpu_inq_o, so a skipped or repeated phase moves the rise of a signal by whole cycles, and the bench checks the exact cycle of each rise. A window counter that is off by one either shifts the end of a no-hit sequence or lets a processor answer in the strobe cycle open a writeback. A lost parked inquire shows as a missing second lookup.

// File: rtl/snoop_relay_pkg.sv
package snoop_relay_pkg;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_LOOKUP,
        SR_REPORT,
        SR_HOLD,
        SR_STROBE,
        SR_WINDOW,
        SR_WRITEBACK
    } sr_state_e;

    // States in which the hit report to the system is driven
    function automatic logic reports_hit(sr_state_e s);
        return (s == SR_REPORT) || (s == SR_HOLD) || (s == SR_STROBE) ||
               (s == SR_WINDOW) || (s == SR_WRITEBACK);
    endfunction

    // States in which the processor address bus is held
    function automatic logic drives_ahold(sr_state_e s, logic release_early);
        case (s)
            SR_HOLD, SR_STROBE, SR_WINDOW: return 1'b1;
            SR_WRITEBACK:                  return !release_early;
            default:                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/snoop_pending_slot.sv
module snoop_pending_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    input  logic          take,
    output logic          out_vld,
    output logic [AW-1:0] out_addr
);
    logic          vld_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else if (in_vld && (!vld_q || take)) begin
            vld_q  <= 1'b1;
            addr_q <= in_addr;
        end else if (take) begin
            vld_q  <= 1'b0;
        end
    end

    assign out_vld  = vld_q;
    assign out_addr = addr_q;

    // R10: a parked inquire stays until the sequencer takes it
    p_park_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !take) |=> (vld_q && $stable(addr_q)));

endmodule

// File: rtl/snoop_resp_window.sv
module snoop_resp_window #(
    parameter int WIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic open_o,
    output logic last_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(WIN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign open_o = (cnt_q != '0);
    assign last_o = (cnt_q == CW'(1));

    // R6: the window never exceeds its configured length
    p_win_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        open_o |-> (cnt_q <= CW'(WIN)));

endmodule

// File: rtl/snoop_seq_fsm.sv
module snoop_seq_fsm
    import snoop_relay_pkg::*;
#(
    parameter int AW              = 32,
    parameter bit RELEASE_ON_HITM = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_addr,
    output logic          take_o,
    input  logic          tag_hit_i,
    input  logic          win_open,
    input  logic          win_last,
    output logic          win_start_o,
    input  logic          cpu_hitm_i,
    input  logic          sys_backoff_i,
    input  logic          cpu_wb_done_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          tag_lookup_o,
    output logic          sys_hit_o,
    output logic          ahold_o,
    output logic          inq_o,
    output logic          wb_grant_o
);
    sr_state_e     state_q, state_d;
    logic [AW-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SR_IDLE:      if (pend_vld) state_d = SR_LOOKUP;
            SR_LOOKUP:    state_d = tag_hit_i ? SR_REPORT : SR_IDLE;
            SR_REPORT:    state_d = SR_HOLD;
            SR_HOLD:      state_d = SR_STROBE;
            SR_STROBE:    state_d = SR_WINDOW;
            SR_WINDOW: begin
                if (win_open && cpu_hitm_i) state_d = SR_WRITEBACK;
                else if (win_last)          state_d = SR_IDLE;
            end
            SR_WRITEBACK: if (wb_grant_o && cpu_wb_done_i) state_d = SR_IDLE;
            default:      state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SR_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_o) addr_q <= pend_addr;
        end
    end

    assign take_o       = (state_q == SR_IDLE) && pend_vld;
    assign win_start_o  = (state_q == SR_STROBE);
    assign cur_addr_o   = addr_q;
    assign tag_lookup_o = (state_q == SR_LOOKUP);
    assign sys_hit_o    = reports_hit(state_q);
    assign ahold_o      = drives_ahold(state_q, RELEASE_ON_HITM);
    assign inq_o        = (state_q == SR_STROBE);
    assign wb_grant_o   = (state_q == SR_WRITEBACK) && !sys_backoff_i;

    // R3: a lookup miss never leads to address-hold
    p_miss_no_ahold_r3: assert property (@(posedge clk) disable iff (rst)
        (tag_lookup_o && !tag_hit_i) |=> !ahold_o);

    // R4: address-hold only ever rises after the hit was already reported
    p_hit_before_ahold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ahold_o) |-> $past(sys_hit_o));

    // R5: forwarded strobe is one cycle long and follows address-hold
    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        inq_o |=> !inq_o);
    p_strobe_after_ahold_r5: assert property (@(posedge clk) disable iff (rst)
        inq_o |-> (ahold_o && $past(ahold_o)));

    // R7: no writeback grant while back-off is asserted
    p_grant_no_backoff_r7: assert property (@(posedge clk) disable iff (rst)
        wb_grant_o |-> !sys_backoff_i);

endmodule

// File: rtl/snoop_relay_ctrl.sv
module snoop_relay_ctrl #(
    parameter int AW              = 32,
    parameter int RESP_WIN        = 2,
    parameter bit RELEASE_ON_HITM = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sys_inq_i,
    input  logic [AW-1:0] sys_inq_addr_i,
    input  logic          sys_backoff_i,
    output logic          sys_hitm_o,
    output logic          tag_lookup_o,
    output logic [AW-1:0] tag_addr_o,
    input  logic          tag_hit_i,
    output logic          cpu_ahold_o,
    output logic          cpu_inq_o,
    output logic [AW-1:0] cpu_inq_addr_o,
    input  logic          cpu_hitm_i,
    output logic          cpu_wb_grant_o,
    input  logic          cpu_wb_done_i
);
    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic          take;
    logic          win_start, win_open, win_last;
    logic [AW-1:0] cur_addr;

    snoop_pending_slot #(.AW(AW)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (sys_inq_i),
        .in_addr  (sys_inq_addr_i),
        .take     (take),
        .out_vld  (pend_vld),
        .out_addr (pend_addr)
    );

    snoop_resp_window #(.WIN(RESP_WIN)) u_win (
        .clk    (clk),
        .rst    (rst),
        .start  (win_start),
        .open_o (win_open),
        .last_o (win_last)
    );

    snoop_seq_fsm #(.AW(AW), .RELEASE_ON_HITM(RELEASE_ON_HITM)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .pend_vld      (pend_vld),
        .pend_addr     (pend_addr),
        .take_o        (take),
        .tag_hit_i     (tag_hit_i),
        .win_open      (win_open),
        .win_last      (win_last),
        .win_start_o   (win_start),
        .cpu_hitm_i    (cpu_hitm_i),
        .sys_backoff_i (sys_backoff_i),
        .cpu_wb_done_i (cpu_wb_done_i),
        .cur_addr_o    (cur_addr),
        .tag_lookup_o  (tag_lookup_o),
        .sys_hit_o     (sys_hitm_o),
        .ahold_o       (cpu_ahold_o),
        .inq_o         (cpu_inq_o),
        .wb_grant_o    (cpu_wb_grant_o)
    );

    assign tag_addr_o     = cur_addr;
    assign cpu_inq_addr_o = cur_addr;

endmodule

// File: tb/sim_snoop_relay_ctrl.sv
module sim_snoop_relay_ctrl;
    localparam int AW = 32;
    localparam int NV = 6;
    // vector table: L2 hit, cycle of processor answer (0 = none), back-off hold
    localparam int V_HIT [NV] = '{1, 1, 1, 0, 1, 1};
    localparam int V_HMK [NV] = '{5, 6, 0, 0, 4, 5};
    localparam int V_BO  [NV] = '{0, 3, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_inq_i = 1'b0;
    logic [AW-1:0] sys_inq_addr_i = '0;
    logic sys_backoff_i = 1'b1;
    logic cpu_hitm_i = 1'b0;
    logic cpu_wb_done_i = 1'b0;
    logic [AW-1:0] hit_addr = '0;

    logic sys_hitm_o, tag_lookup_o, tag_hit_i, cpu_ahold_o, cpu_inq_o, cpu_wb_grant_o;
    logic [AW-1:0] tag_addr_o, cpu_inq_addr_o;
    logic hitm_1, look_1, hit_1, ahold_1, inq_1, grant_1;
    logic [AW-1:0] taddr_1, iaddr_1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign tag_hit_i = tag_lookup_o && (tag_addr_o == hit_addr);
    assign hit_1     = look_1 && (taddr_1 == hit_addr);

    snoop_relay_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .sys_inq_i(sys_inq_i), .sys_inq_addr_i(sys_inq_addr_i),
        .sys_backoff_i(sys_backoff_i), .sys_hitm_o(sys_hitm_o), .tag_lookup_o(tag_lookup_o),
        .tag_addr_o(tag_addr_o), .tag_hit_i(tag_hit_i), .cpu_ahold_o(cpu_ahold_o),
        .cpu_inq_o(cpu_inq_o), .cpu_inq_addr_o(cpu_inq_addr_o), .cpu_hitm_i(cpu_hitm_i),
        .cpu_wb_grant_o(cpu_wb_grant_o), .cpu_wb_done_i(cpu_wb_done_i)
    );

    snoop_relay_ctrl #(.AW(AW), .RELEASE_ON_HITM(1'b1)) u1 (
        .clk(clk), .rst(rst), .sys_inq_i(sys_inq_i), .sys_inq_addr_i(sys_inq_addr_i),
        .sys_backoff_i(sys_backoff_i), .sys_hitm_o(hitm_1), .tag_lookup_o(look_1),
        .tag_addr_o(taddr_1), .tag_hit_i(hit_1), .cpu_ahold_o(ahold_1),
        .cpu_inq_o(inq_1), .cpu_inq_addr_o(iaddr_1), .cpu_hitm_i(cpu_hitm_i),
        .cpu_wb_grant_o(grant_1), .cpu_wb_done_i(cpu_wb_done_i)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs_u0();
        return int'({sys_hitm_o, tag_lookup_o, cpu_ahold_o, cpu_inq_o, cpu_wb_grant_o});
    endfunction

    // Runs one inquire; called at a falling edge. Observation k follows edge k.
    task automatic run_case(input string tag, input logic [AW-1:0] a, input bit l2hit,
                            input int hmk, input int bol, input bit second,
                            input logic [AW-1:0] a2);
        int f_hit = -1, f_ah = -1, inq_k = -1, inq_n = 0, g_k = -1, g1_k = -1;
        int end_k = -1, lk_k = -1, lk2_k = -1;
        bit inq_addr_ok = 1'b1, bad_grant = 1'b0, ah_g0 = 1'b0, ah_g1 = 1'b1, ah1_after = 1'b1;
        hit_addr       = l2hit ? a : ~a;
        sys_backoff_i  = 1'b1;
        sys_inq_i      = 1'b1;
        sys_inq_addr_i = a;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            sys_inq_i      = second && (k == 3);
            sys_inq_addr_i = (second && k == 3) ? a2 : a;
            cpu_hitm_i     = (hmk > 0) && (k == hmk);
            cpu_wb_done_i  = 1'b0;
            if (hmk >= 5 && k == hmk + 1 + bol) sys_backoff_i = 1'b0;
            #1;
            if (cpu_wb_grant_o && sys_backoff_i) bad_grant = 1'b1;
            if (cpu_wb_grant_o && g_k < 0) begin
                g_k = k; ah_g0 = cpu_ahold_o; ah_g1 = ahold_1; cpu_wb_done_i = 1'b1;
            end
            if (grant_1 && g1_k < 0) g1_k = k;
            if (hmk >= 5 && k == hmk + 1) ah1_after = ahold_1;
            if (sys_hitm_o && f_hit < 0) f_hit = k;
            if (cpu_ahold_o && f_ah < 0) f_ah = k;
            if (cpu_inq_o) begin
                inq_n++;
                if (inq_k < 0) inq_k = k;
                if (cpu_inq_addr_o != a) inq_addr_ok = 1'b0;
            end
            if (tag_lookup_o && tag_addr_o == a && lk_k < 0) lk_k = k;
            if (second && tag_lookup_o && tag_addr_o == a2 && lk2_k < 0) lk2_k = k;
            if (k >= 2 && end_k < 0 && !sys_hitm_o && !cpu_ahold_o) end_k = k;
        end
        sys_backoff_i = 1'b1;
        cpu_hitm_i    = 1'b0;
        cpu_wb_done_i = 1'b0;

        check_eq({tag, " R2 lookup cycle"}, lk_k, 1);
        if (l2hit) begin
            check_eq({tag, " R4 hit report cycle"}, f_hit, 2);
            check_eq({tag, " R4 ahold cycle"}, f_ah, 3);
            check_eq({tag, " R5 strobe cycle"}, inq_k, 4);
            check_eq({tag, " R5 strobe count"}, inq_n, 1);
            check_eq({tag, " R5 strobe address"}, int'(inq_addr_ok), 1);
            if (hmk >= 5) begin
                check_eq({tag, " R7 grant cycle"}, g_k, hmk + 1 + bol);
                check_eq({tag, " R7 grant under backoff"}, int'(bad_grant), 0);
                check_eq({tag, " R8 ahold held at grant"}, int'(ah_g0), 1);
                check_eq({tag, " R8 end cycle"}, end_k, g_k + 1);
                check_eq({tag, " R9 early ahold at grant"}, int'(ah_g1), 0);
                check_eq({tag, " R9 early ahold after hit"}, int'(ah1_after), 0);
                check_eq({tag, " R9 grant cycle"}, g1_k, g_k);
            end else begin
                check_eq({tag, " R6 end cycle"}, end_k, 7);
                check_eq({tag, " R6 no grant"}, g_k, -1);
            end
        end else begin
            check_eq({tag, " R3 no hit report"}, f_hit, -1);
            check_eq({tag, " R3 no ahold"}, f_ah, -1);
            check_eq({tag, " R3 no strobe"}, inq_n, 0);
            check_eq({tag, " R3 idle cycle"}, end_k, 2);
        end
        if (second) check_eq({tag, " R10 parked lookup"}, lk2_k, end_k + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with an inquire presented during reset
        sys_inq_i = 1'b1;
        sys_inq_addr_i = 32'hDEAD_0000;
        repeat (3) @(negedge clk);
        check_eq("R1 outputs in reset", outs_u0(), 0);
        sys_inq_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 outputs after reset", outs_u0(), 0);

        for (int i = 0; i < NV; i++)
            run_case($sformatf("vec%0d", i), 32'h1000_0040 + AW'(i) * 32'h40,
                     V_HIT[i] != 0, V_HMK[i], V_BO[i], 1'b0, '0);

        // R10: second inquire arrives mid-sequence and must not be lost
        run_case("park", 32'h2000_0100, 1'b1, 5, 2, 1'b1, 32'h2000_0200);

        // R1: reset in the middle of a hit sequence drops address-hold
        hit_addr = 32'h3000_0000;
        sys_inq_addr_i = 32'h3000_0000;
        sys_inq_i = 1'b1;
        @(negedge clk);
        sys_inq_i = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 ahold up before reset", int'(cpu_ahold_o), 1);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 ahold after mid reset", int'(cpu_ahold_o), 0);
        check_eq("R1 hit report after mid reset", int'(sys_hitm_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule